// File: doc/BRIEF.md
# Dual-Output Interrupt Aggregator

This block gathers 224 interrupt request lines, organised as 7 groups of 32, and funnels them onto two parent interrupt outputs. Line n lives in group n/32 at bit n%32 of every per-line word. For each line, software picks level or edge detection, the active sense, whether the line is enabled, and which of the two outputs it feeds. Edge events are latched until software acknowledges them with a write-one-to-clear. Level lines simply follow their input.

Software reaches the block over a plain 32-bit register bus that has two address windows. Window 0 holds the configuration arrays. Window 1 holds the acknowledge array, the enabled-and-routed status words for each output, and a packed summary word that shows which groups have something pending for each output. Each parent output is the registered OR of its status words.

Top module: `intc_dual`

## Requirements
- R1: Out of reset every mapped word in both windows reads 0, both interrupt outputs are low, and all lines are therefore disabled.
- R2: Window 0 holds four arrays of 7 words, each of which can be read and written: trigger mode at byte 0, sense at byte 28, output select at byte 56 and enable at byte 84. Word g of each array carries lines 32g..32g+31, with line n at bit n%32.
- R3: A line whose trigger bit is 0 is level sensitive. Its pending state equals the synchronised input when its sense bit is 0, and the inverted input when its sense bit is 1. Writing 1 to its acknowledge bit has no effect.
- R4: A line whose trigger bit is 1 latches pending on a rising edge of the synchronised input when its sense bit is 0, and on a falling edge when its sense bit is 1. Pending stays set after the input returns to idle.
- R5: Window 1 bytes 0..24 form the acknowledge array. Writing 1 to a bit clears that line's latched edge, and writing 0 leaves it unchanged. The array always reads 0.
- R6: Status for output 0 (window 1, byte 56 + 4g) is pending AND enable AND select. Status for output 1 (window 1, byte 28 + 4g) is pending AND enable AND NOT select. A select bit of 1 routes a line to output 0. A disabled line still keeps its latched edge.
- R7: The summary word at window 1 byte 124 sets bit g when output-1 status word g is nonzero, and bit 8+g when output-0 status word g is nonzero. All its other bits read 0.
- R8: irq_out0 and irq_out1 are the registered OR of their status words. A level change at irq_in reaches the output on the third rising clock edge after it is applied.
- R9: Read data appears one cycle after the address. Writes to status, summary, unmapped or unaligned addresses change nothing. Reads of unmapped or unaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_win | input | 1 | Window select: 0 configuration, 1 acknowledge/status |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 8 | Byte address within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | 224 | Asynchronous interrupt request lines |
| irq_out0 | output | 1 | Parent interrupt 0 |
| irq_out1 | output | 1 | Parent interrupt 1 |

## Verification
A corrupted configuration bit or a stuck latched edge shows up at two places. It appears on the per-output status word on the next register read, and on a parent output three edges after the input changes. Walking a single active line across all 224 positions, with alternating routing, exposes a wrong group or bit index, a swapped output, or a misplaced summary field on the first read after the line settles. The edge, acknowledge and disable sequences catch a pending bit that fails to hold, fails to clear, or clears when it should not.

// File: rtl/intc_dual_pkg.sv
`timescale 1ns/1ps
package intc_dual_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned NUM_ARR      = 4;
  localparam int unsigned SUM_WORD     = 31;
  localparam int unsigned SUM_OUT0_LSB = 8;

  typedef logic [WORD_W-1:0] word_t;

  // order of the configuration arrays in window 0
  typedef enum int unsigned {
    ARR_TRIG  = 0,
    ARR_SENSE = 1,
    ARR_SEL   = 2,
    ARR_EN    = 3
  } cfg_arr_e;
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
  parameter int unsigned WIDTH  = 224,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prv
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [WIDTH-1:0] stg [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign cur = stg[STAGES-1];
  assign prv = stg[STAGES];
endmodule

// File: rtl/intc_pending.sv
`timescale 1ns/1ps
module intc_pending #(
  parameter int unsigned WIDTH = 224
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prv,
  input  logic [WIDTH-1:0] trig,
  input  logic [WIDTH-1:0] sense,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] pend,
  output logic [WIDTH-1:0] edge_pend
);
  logic [WIDTH-1:0] rise, fall, det;

  assign rise = cur & ~prv;
  assign fall = ~cur & prv;
  assign det  = trig & ((rise & ~sense) | (fall & sense));

  // a new edge wins over an acknowledge in the same cycle;
  // leaving edge mode drops any stale latch
  always_ff @(posedge clk) begin
    if (rst) edge_pend <= '0;
    else     edge_pend <= ((edge_pend & ~clr) | det) & trig;
  end

  assign pend = (trig & edge_pend) | (~trig & (cur ^ sense));
endmodule

// File: rtl/intc_route.sv
`timescale 1ns/1ps
module intc_route
  import intc_dual_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 7,
  localparam int unsigned NUM_LINES = NUM_GROUPS * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  pend,
  input  logic [NUM_LINES-1:0]  en,
  input  logic [NUM_LINES-1:0]  to0,
  output logic [NUM_LINES-1:0]  ms0,
  output logic [NUM_LINES-1:0]  ms1,
  output logic [NUM_GROUPS-1:0] sum0,
  output logic [NUM_GROUPS-1:0] sum1,
  output logic                  irq0,
  output logic                  irq1
);
  assign ms0 = pend & en & to0;
  assign ms1 = pend & en & ~to0;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign sum0[g] = |ms0[g*WORD_W +: WORD_W];
    assign sum1[g] = |ms1[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= |sum0;
      irq1 <= |sum1;
    end
  end
endmodule

// File: rtl/intc_dual.sv
`timescale 1ns/1ps
module intc_dual
  import intc_dual_pkg::*;
#(
  parameter int unsigned NUM_GROUPS  = 7,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_LINES  = NUM_GROUPS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_win,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 irq_out0,
  output logic                 irq_out1
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  word_t cfg_q [NUM_ARR][NUM_GROUPS];

  logic [NUM_LINES-1:0] trig_v, sense_v, sel_v, en_v, clr_v;
  logic [NUM_LINES-1:0] cur_v, prv_v, pend_v, edge_pend_v, ms0_v, ms1_v;
  logic [NUM_GROUPS-1:0] sum0, sum1;

  // flatten configuration words and decode acknowledge writes
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_flat
    assign trig_v [g*WORD_W +: WORD_W] = cfg_q[ARR_TRIG][g];
    assign sense_v[g*WORD_W +: WORD_W] = cfg_q[ARR_SENSE][g];
    assign sel_v  [g*WORD_W +: WORD_W] = cfg_q[ARR_SEL][g];
    assign en_v   [g*WORD_W +: WORD_W] = cfg_q[ARR_EN][g];
    assign clr_v  [g*WORD_W +: WORD_W] =
      (bus_wr && bus_win && aligned && (int'(widx) == g)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < NUM_ARR; a++)
        for (int g = 0; g < NUM_GROUPS; g++)
          cfg_q[a][g] <= '0;
    end else if (bus_wr && !bus_win && aligned) begin
      for (int a = 0; a < NUM_ARR; a++)
        for (int g = 0; g < NUM_GROUPS; g++)
          if (int'(widx) == a * NUM_GROUPS + g) cfg_q[a][g] <= bus_wdata;
    end
  end

  // read path
  word_t summ, rd_d;

  always_comb begin
    summ = '0;
    summ[NUM_GROUPS-1:0]             = sum1;
    summ[SUM_OUT0_LSB +: NUM_GROUPS] = sum0;
  end

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      if (!bus_win) begin
        for (int a = 0; a < NUM_ARR; a++)
          for (int g = 0; g < NUM_GROUPS; g++)
            if (int'(widx) == a * NUM_GROUPS + g) rd_d = cfg_q[a][g];
      end else begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (int'(widx) == NUM_GROUPS + g)     rd_d = ms1_v[g*WORD_W +: WORD_W];
          if (int'(widx) == 2 * NUM_GROUPS + g) rd_d = ms0_v[g*WORD_W +: WORD_W];
        end
        if (int'(widx) == SUM_WORD) rd_d = summ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  intc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (irq_in),
    .cur (cur_v),
    .prv (prv_v)
  );

  intc_pending #(.WIDTH(NUM_LINES)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .cur       (cur_v),
    .prv       (prv_v),
    .trig      (trig_v),
    .sense     (sense_v),
    .clr       (clr_v),
    .pend      (pend_v),
    .edge_pend (edge_pend_v)
  );

  intc_route #(.NUM_GROUPS(NUM_GROUPS)) u_route (
    .clk  (clk),
    .rst  (rst),
    .pend (pend_v),
    .en   (en_v),
    .to0  (sel_v),
    .ms0  (ms0_v),
    .ms1  (ms1_v),
    .sum0 (sum0),
    .sum1 (sum1),
    .irq0 (irq_out0),
    .irq1 (irq_out1)
  );
endmodule

// File: rtl/intc_dual_chk.sv
`timescale 1ns/1ps
module intc_dual_chk #(
  parameter int unsigned NUM_LINES  = 224,
  parameter int unsigned NUM_GROUPS = 7,
  parameter int unsigned ADDR_W     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_win,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic                 irq_out0,
  input logic                 irq_out1,
  input logic [NUM_LINES-1:0] ms0,
  input logic [NUM_LINES-1:0] ms1,
  input logic [NUM_LINES-1:0] edge_pend,
  input logic [NUM_LINES-1:0] clr,
  input logic [NUM_LINES-1:0] trig
);
  // R1: reset drives outputs and read data low
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_out0 && !irq_out1 && bus_rdata == '0));

  // R4: an edge latch not acknowledged holds
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((edge_pend & $past(edge_pend & ~clr & trig)) == $past(edge_pend & ~clr & trig)));

  // R6: a line never reports to both outputs
  p_route_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (ms0 & ms1) == '0);

  // R8: each parent output follows its status one cycle later
  p_out0_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out0 == $past(|ms0)));

  p_out1_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out1 == $past(|ms1)));

  // R9: unmapped window-0 addresses read zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!bus_win && int'(bus_addr) >= 16 * NUM_GROUPS) |=> (bus_rdata == '0));
endmodule

bind intc_dual intc_dual_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_GROUPS(NUM_GROUPS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_win   (bus_win),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out0  (irq_out0),
  .irq_out1  (irq_out1),
  .ms0       (ms0_v),
  .ms1       (ms1_v),
  .edge_pend (edge_pend_v),
  .clr       (clr_v),
  .trig      (trig_v)
);

// File: tb/test_intc_dual.sv
`timescale 1ns/1ps
module test_intc_dual;
  localparam int NG = 7;
  localparam int NL = NG * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          win = 1'b0;
  logic          wr  = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NL-1:0] irq = '0;
  logic          o0, o1;
  logic [31:0]   r;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  intc_dual i_intc_dual (
    .clk(clk), .rst(rst), .bus_win(win), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_in(irq),
    .irq_out0(o0), .irq_out1(o1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic w, input int off, input logic [31:0] d);
    @(negedge clk);
    win = w; addr = 8'(off); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic w, input int off, output logic [31:0] d);
    @(negedge clk);
    win = w; addr = 8'(off); wr = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  function automatic logic [31:0] pat(input int a, input int g);
    return (32'h1357_9BDF * (a + 1)) ^ (32'(g) << 12) ^ 32'(a * 7 + g);
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 outputs", {30'b0, o1, o0}, 32'h0);
    for (int i = 0; i < 4 * NG; i++) begin
      rd_reg(1'b0, 4 * i, r); chk("R1 cfg word", r, 32'h0);
    end
    for (int i = 0; i < 32; i++) begin
      rd_reg(1'b1, 4 * i, r); chk("R1 window1 word", r, 32'h0);
    end

    // R2 readback of the configuration arrays
    for (int a = 0; a < 4; a++)
      for (int g = 0; g < NG; g++) wr_reg(1'b0, 28 * a + 4 * g, pat(a, g));
    // R9 ignored writes: unmapped and unaligned
    wr_reg(1'b0, 112, 32'hFFFF_FFFF);
    wr_reg(1'b0, 2, 32'hFFFF_FFFF);
    for (int a = 0; a < 4; a++)
      for (int g = 0; g < NG; g++) begin
        rd_reg(1'b0, 28 * a + 4 * g, r); chk("R2 readback", r, pat(a, g));
      end
    for (int i = 4 * NG; i < 64; i++) begin
      rd_reg(1'b0, 4 * i, r); chk("R9 unmapped w0", r, 32'h0);
    end
    rd_reg(1'b0, 1, r); chk("R9 unaligned read", r, 32'h0);
    for (int i = 3 * NG; i < 31; i++) begin
      rd_reg(1'b1, 4 * i, r); chk("R9 unmapped w1", r, 32'h0);
    end

    // level configuration; even bit positions route to output 0
    for (int g = 0; g < NG; g++) begin
      wr_reg(1'b0, 4 * g, 32'h0);
      wr_reg(1'b0, 28 + 4 * g, 32'h0);
      wr_reg(1'b0, 56 + 4 * g, 32'h5555_5555);
      wr_reg(1'b0, 84 + 4 * g, 32'hFFFF_FFFF);
    end
    settle();
    rd_reg(1'b1, 124, r); chk("R3 idle summary", r, 32'h0);

    // R8 exact latency on line 3 (routed to output 1)
    @(negedge clk); irq[3] = 1'b1;
    @(negedge clk); chk("R8 latency edge1", {31'b0, o1}, 32'h0);
    @(negedge clk); chk("R8 latency edge2", {31'b0, o1}, 32'h0);
    @(negedge clk); chk("R8 latency edge3", {31'b0, o1}, 32'h1);
    irq = '0; settle();

    // walking single active line over every position
    for (int n = 0; n < NL; n++) begin
      int g, b;
      bit to0;
      g = n / 32; b = n % 32; to0 = (b % 2 == 0);
      irq = '0; irq[n] = 1'b1;
      settle();
      rd_reg(1'b1, to0 ? 56 + 4 * g : 28 + 4 * g, r); chk("R6 status own", r, 32'h1 << b);
      rd_reg(1'b1, to0 ? 28 + 4 * g : 56 + 4 * g, r); chk("R6 status other", r, 32'h0);
      rd_reg(1'b1, 124, r); chk("R7 summary", r, to0 ? (32'h1 << (8 + g)) : (32'h1 << g));
      chk("R8 outputs", {30'b0, o1, o0}, to0 ? 32'h1 : 32'h2);
      irq = '0;
      settle();
      rd_reg(1'b1, 124, r); chk("R3 level released", r, 32'h0);
    end

    // R4 rising edge on line 40 (group 1 bit 8, output 0)
    wr_reg(1'b0, 4, 32'h0000_0100);
    irq[40] = 1'b1; settle();
    irq[40] = 1'b0; settle();
    rd_reg(1'b1, 60, r); chk("R4 rising latched", r, 32'h0000_0100);
    wr_reg(1'b1, 4, 32'h0);
    rd_reg(1'b1, 60, r); chk("R5 zero write kept", r, 32'h0000_0100);
    wr_reg(1'b1, 32, 32'hFFFF_FFFF);
    wr_reg(1'b1, 124, 32'hFFFF_FFFF);
    wr_reg(1'b1, 100, 32'hFFFF_FFFF);
    rd_reg(1'b1, 60, r); chk("R9 ignored writes", r, 32'h0000_0100);
    rd_reg(1'b1, 4, r); chk("R5 ack reads zero", r, 32'h0);
    chk("R8 out0 high", {31'b0, o0}, 32'h1);
    wr_reg(1'b1, 4, 32'h0000_0100);
    rd_reg(1'b1, 60, r); chk("R5 cleared", r, 32'h0);
    settle();
    chk("R8 out0 low", {31'b0, o0}, 32'h0);

    // R4 falling edge
    wr_reg(1'b0, 32, 32'h0000_0100);
    irq[40] = 1'b1; settle();
    rd_reg(1'b1, 60, r); chk("R4 rise ignored", r, 32'h0);
    irq[40] = 1'b0; settle();
    rd_reg(1'b1, 60, r); chk("R4 falling latched", r, 32'h0000_0100);
    wr_reg(1'b1, 4, 32'h0000_0100);
    rd_reg(1'b1, 60, r); chk("R5 falling cleared", r, 32'h0);

    // R6 disabled line keeps its latch
    wr_reg(1'b0, 88, ~32'h0000_0100);
    irq[40] = 1'b1; settle();
    irq[40] = 1'b0; settle();
    rd_reg(1'b1, 60, r); chk("R6 disabled hidden", r, 32'h0);
    chk("R6 out0 quiet", {31'b0, o0}, 32'h0);
    wr_reg(1'b0, 88, 32'hFFFF_FFFF);
    rd_reg(1'b1, 60, r); chk("R6 enable reveals", r, 32'h0000_0100);
    wr_reg(1'b1, 4, 32'h0000_0100);

    // R3 active-low level line 41 (group 1 bit 9, output 1) ignores ack
    wr_reg(1'b0, 32, 32'h0000_0200);
    settle();
    rd_reg(1'b1, 32, r); chk("R3 active low", r, 32'h0000_0200);
    wr_reg(1'b1, 4, 32'h0000_0200);
    rd_reg(1'b1, 32, r); chk("R3 ack ignored", r, 32'h0000_0200);
    irq[41] = 1'b1; settle();
    rd_reg(1'b1, 32, r); chk("R3 inactive high", r, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule